// File: doc/BRIEF.md
# PLL Spread-Spectrum Modulator

This block sits in front of the delta-sigma stage of a fractional-N PLL. It takes the nominal feedback divide value, an integer part and a 24-bit fraction, and adds a slowly varying signed offset to it. The offset follows a triangle wave, so the PLL output frequency sweeps back and forth around its set point and its energy spreads over a band instead of sitting in one narrow line. This reduces radiated emission. The wave is 128 points long. A 4-bit rate divider stretches each point over several reference ticks, and a 5-bit amplitude sets the peak deviation in steps of 0.1 %.

Software writes one 13-bit control word. The fields are bypass, modulation disable, modulator reset, a down-spread select, the rate divider and the amplitude. The expected enable order is:

1. Program the amplitude, rate and direction fields.
2. Clear bypass and disable.
3. Pulse the modulator reset.

Amplitude, rate and direction can still be changed while the modulator runs. Without modulation, the nominal value passes through. Software is expected to set the nominal fraction to zero when spreading, so that the average frequency is not shifted. Each clock of the block is one tick of the divided reference.

Top module: `spread_mod_top`

## Requirements
- R1: While rst_n is low, out_int and out_frac are 0 and out_valid is 0.
- R2: When frac_mode is 0, or ctrl_word bit 0 (bypass) is 1, or ctrl_word bit 1 (disable) is 1, the output one cycle later equals the nominal {nom_int, nom_frac}. In that case out_valid stays 0, and the table index and rate counter are held at 0.
- R3: While ctrl_word bit 2 (modulator reset) is 1, the table index and the rate counter are held at 0 and the output equals the nominal value with out_valid at 0. After the bit is released, stepping starts again from index 0.
- R4: While running, the table index advances by one, modulo 128, each time the rate counter has seen max(DIVVAL,1) ticks. DIVVAL is ctrl_word bits 7:4. out_valid is 1 for exactly the cycle after each advance, giving 128 pulses per modulation period.
- R5: A DIVVAL of 0 behaves as DIVVAL of 1, so the index advances on every tick.
- R6: The peak deviation, in fraction LSBs, is round-to-nearest of T*SPREAD/1000. T is the 36-bit value {nom_int, nom_frac} and SPREAD is ctrl_word bits 12:8. It is recomputed at once when either input changes. SPREAD = 0 gives the nominal value at all times.
- R7: With ctrl_word bit 3 = 0 (center spread), the offset for index i is floor(P*(2t-64)/64). Here P is the peak deviation and t = i for i < 64, or 128-i otherwise. The offset runs from -P at index 0 to +P at index 64.
- R8: With ctrl_word bit 3 = 1 (down spread), the offset is -floor(P*t/64). It runs from 0 at index 0 down to -P at index 64, so the output never exceeds the nominal value.
- R9: The output {out_int, out_frac} equals (T + offset) modulo 2^36. A carry out of the fraction moves into the integer part, and so does a borrow.
- R10: Amplitude, rate and direction changes made while running take effect on the next edge, without a modulator reset. The table index continues from where it was.
- R11: The output and out_valid are registered. The value presented after an edge belongs to the table index reached on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Divided reference clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 13 | Control: [0] bypass, [1] disable, [2] modulator reset, [3] down-spread, [7:4] DIVVAL, [12:8] SPREAD |
| frac_mode | input | 1 | 1 when the PLL runs in fractional mode |
| nom_int | input | 12 | Nominal integer feedback divide value |
| nom_frac | input | 24 | Nominal fractional feedback divide value |
| out_int | output | 12 | Modulated integer divide value |
| out_frac | output | 24 | Modulated fractional divide value |
| out_valid | output | 1 | One-cycle pulse after each table index advance |

## Verification
The table-index advance can fall in the same cycle as a change of the control word. The change may be a new amplitude or direction, a new rate, or the modulator reset being asserted. The bench provokes this by running with a rate divider of 1, so every edge is an advance, and then rewriting the amplitude, direction and rate while running, and pulsing the modulator reset mid-sweep. A cycle-level model computed from the requirements judges every output. It checks that the new peak and direction apply to the index reached on that edge, that the index continues, and that a reset wins over the advance.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

   // control field widths fixed by the register layout decoded by the PLL wrapper
   localparam int CTRL_DIV_W = 4;
   localparam int CTRL_AMP_W = 5;
   localparam int CTRL_W     = 4 + CTRL_DIV_W + CTRL_AMP_W;

   // amplitude unit is one part in a thousand of the nominal divide value
   localparam int AMP_DEN    = 1000;

   typedef struct packed {
      logic [CTRL_AMP_W-1:0] amp;
      logic [CTRL_DIV_W-1:0] rate;
      logic                  down;
      logic                  mod_rst;
      logic                  dis;
      logic                  bypass;
   } ssm_ctrl_t;

endpackage

// File: rtl/ssm_rate_stepper.sv
module ssm_rate_stepper #(
   parameter int DIV_W = 4,
   parameter int IDX_W = 7
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] rate,
   output logic [IDX_W-1:0] idx_nx,
   output logic             adv
);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] cnt_nx;
   logic [DIV_W-1:0] eff_rate;
   logic [IDX_W-1:0] idx_q;

   // a zero rate would stall the sweep; it counts as one tick per point
   assign eff_rate = (rate == '0) ? DIV_W'(1) : rate;

   always_comb begin
      if (!run) begin
         cnt_nx = '0;
         idx_nx = '0;
         adv    = 1'b0;
      end else if (cnt_q >= eff_rate - DIV_W'(1)) begin
         // >= also covers a rate lowered below the running count
         cnt_nx = '0;
         idx_nx = idx_q + IDX_W'(1);
         adv    = 1'b1;
      end else begin
         cnt_nx = cnt_q + DIV_W'(1);
         idx_nx = idx_q;
         adv    = 1'b0;
      end
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         idx_q <= '0;
      end else begin
         cnt_q <= cnt_nx;
         idx_q <= idx_nx;
      end
   end

endmodule

// File: rtl/ssm_peak_calc.sv
module ssm_peak_calc #(
   parameter int TOT_W = 36,
   parameter int AMP_W = 5,
   parameter int DEN   = 1000
) (
   input  logic [TOT_W-1:0] total,
   input  logic [AMP_W-1:0] amp,
   output logic [TOT_W-1:0] peak
);

   // round(total*amp/DEN) through a reciprocal multiply that is exact
   // for every numerator below 2**NUM_W
   localparam int NUM_W   = TOT_W + AMP_W + 1;
   localparam int DEN_LOG = $clog2(DEN);
   localparam int SHIFT   = NUM_W + DEN_LOG;
   localparam int RCP_W   = SHIFT - DEN_LOG + 1;
   localparam int PROD_W  = NUM_W + RCP_W;
   localparam logic [63:0] RCP_FULL = ((64'd1 << SHIFT) + 64'(DEN - 1)) / 64'(DEN);
   localparam logic [RCP_W-1:0] RCP = RCP_FULL[RCP_W-1:0];

   generate
      if (SHIFT > 62) begin : g_bad_shift
         $error("ssm_peak_calc: TOT_W+AMP_W too wide for the reciprocal constant");
      end
      if (DEN < 2) begin : g_bad_den
         $error("ssm_peak_calc: DEN must be at least 2");
      end
   endgenerate

   logic [NUM_W-1:0]  num;
   logic [PROD_W-1:0] prod;

   assign num  = NUM_W'(total) * NUM_W'(amp) + NUM_W'(DEN / 2);
   assign prod = PROD_W'(num) * PROD_W'(RCP);
   assign peak = TOT_W'(prod >> SHIFT);

endmodule

// File: rtl/ssm_wave_shaper.sv
module ssm_wave_shaper #(
   parameter int IDX_W = 7,
   parameter int PK_W  = 36
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [PK_W-1:0]  peak,
   input  logic             down,
   output logic [PK_W-1:0]  ofs_mod
);

   // triangle height t rises 0..HALF over the first half, falls back over the second
   localparam int HALF     = 2 ** (IDX_W - 1);
   localparam int LOG_HALF = IDX_W - 1;
   localparam int CW       = IDX_W + 2;
   localparam int CP_W     = PK_W + 2 + CW;
   localparam int DP_W     = PK_W + IDX_W;

   logic [IDX_W-1:0]       tri_h;
   logic signed [CW-1:0]   ctr_w;
   logic signed [CP_W-1:0] ctr_prod;
   logic [DP_W-1:0]        dn_prod;
   logic [PK_W-1:0]        ctr_ofs;
   logic [PK_W-1:0]        dn_ofs;

   // 128-idx taken modulo 2**IDX_W gives HALF at the apex
   assign tri_h = idx[IDX_W-1] ? (IDX_W'(0) - idx) : idx;

   // center: weight runs -HALF..+HALF, arithmetic shift rounds toward minus infinity
   assign ctr_w    = signed'({1'b0, tri_h, 1'b0}) - signed'(CW'(HALF));
   assign ctr_prod = signed'(CP_W'({2'b00, peak})) * CP_W'(ctr_w);
   assign ctr_ofs  = PK_W'(ctr_prod >>> LOG_HALF);

   // down: magnitude 0..peak, always subtracted
   assign dn_prod  = DP_W'(peak) * DP_W'(tri_h);
   assign dn_ofs   = PK_W'(0) - PK_W'(dn_prod >> LOG_HALF);

   assign ofs_mod  = down ? dn_ofs : ctr_ofs;

endmodule

// File: rtl/spread_mod_top.sv
module spread_mod_top #(
   parameter int INT_W     = 12,
   parameter int FRAC_W    = 24,
   parameter int TABLE_PTS = 128
) (
   input  logic                       clk_ref,
   input  logic                       rst_n,
   input  logic [ssm_pkg::CTRL_W-1:0] ctrl_word,
   input  logic                       frac_mode,
   input  logic [INT_W-1:0]           nom_int,
   input  logic [FRAC_W-1:0]          nom_frac,
   output logic [INT_W-1:0]           out_int,
   output logic [FRAC_W-1:0]          out_frac,
   output logic                       out_valid
);

   localparam int TOT_W = INT_W + FRAC_W;
   localparam int IDX_W = $clog2(TABLE_PTS);

   generate
      if (TABLE_PTS < 4 || (TABLE_PTS & (TABLE_PTS - 1)) != 0) begin : g_bad_pts
         $error("spread_mod_top: TABLE_PTS must be a power of two of at least 4");
      end
      if (INT_W < 1 || FRAC_W < 1) begin : g_bad_w
         $error("spread_mod_top: INT_W and FRAC_W must be positive");
      end
   endgenerate

   ssm_pkg::ssm_ctrl_t cw;
   logic               mod_active;
   logic               mod_run;
   logic [TOT_W-1:0]   nom_total;
   logic [TOT_W-1:0]   peak;
   logic [IDX_W-1:0]   idx_nx;
   logic               adv;
   logic [TOT_W-1:0]   wave_ofs;
   logic [TOT_W-1:0]   sel_ofs;
   logic [TOT_W-1:0]   sum_q;
   logic               valid_q;

   assign cw         = ctrl_word;
   assign mod_active = frac_mode & ~cw.bypass & ~cw.dis;
   assign mod_run    = mod_active & ~cw.mod_rst;
   assign nom_total  = {nom_int, nom_frac};

   ssm_rate_stepper #(
      .DIV_W (ssm_pkg::CTRL_DIV_W),
      .IDX_W (IDX_W)
   ) u_step (
      .clk_ref (clk_ref),
      .rst_n   (rst_n),
      .run     (mod_run),
      .rate    (cw.rate),
      .idx_nx  (idx_nx),
      .adv     (adv)
   );

   ssm_peak_calc #(
      .TOT_W (TOT_W),
      .AMP_W (ssm_pkg::CTRL_AMP_W),
      .DEN   (ssm_pkg::AMP_DEN)
   ) u_peak (
      .total (nom_total),
      .amp   (cw.amp),
      .peak  (peak)
   );

   ssm_wave_shaper #(
      .IDX_W (IDX_W),
      .PK_W  (TOT_W)
   ) u_wave (
      .idx     (idx_nx),
      .peak    (peak),
      .down    (cw.down),
      .ofs_mod (wave_ofs)
   );

   assign sel_ofs = mod_run ? wave_ofs : '0;

   // modular add: carry and borrow cross from fraction into integer part
   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         sum_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         sum_q   <= nom_total + sel_ofs;
         valid_q <= adv;
      end
   end

   assign out_int   = sum_q[TOT_W-1:FRAC_W];
   assign out_frac  = sum_q[FRAC_W-1:0];
   assign out_valid = valid_q;

endmodule

// File: rtl/ssm_chk.sv
module ssm_chk #(
   parameter int INT_W  = 12,
   parameter int FRAC_W = 24
) (
   input logic                       clk_ref,
   input logic                       rst_n,
   input logic [ssm_pkg::CTRL_W-1:0] ctrl_word,
   input logic                       frac_mode,
   input logic [INT_W-1:0]           nom_int,
   input logic [FRAC_W-1:0]          nom_frac,
   input logic [INT_W-1:0]           out_int,
   input logic [FRAC_W-1:0]          out_frac,
   input logic                       out_valid
);

   ssm_pkg::ssm_ctrl_t c;
   logic               pass_cond;
   logic               down_run;
   logic [INT_W+FRAC_W-1:0] n_tot;
   logic [INT_W+FRAC_W-1:0] o_tot;

   assign c         = ctrl_word;
   assign pass_cond = ~frac_mode | c.bypass | c.dis;
   assign down_run  = frac_mode & ~c.bypass & ~c.dis & c.down;
   assign n_tot     = {nom_int, nom_frac};
   assign o_tot     = {out_int, out_frac};

   // R2
   pass_through_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      pass_cond |=> (o_tot == $past(n_tot)) && !out_valid);

   // R3
   mod_reset_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      c.mod_rst |=> (o_tot == $past(n_tot)) && !out_valid);

   // R4
   valid_single_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (out_valid && (c.rate >= 4'd2)) |=> !out_valid);

   // R6
   zero_amp_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (c.amp == '0) |=> (o_tot == $past(n_tot)));

   // R8
   down_below_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      down_run |=> (o_tot <= $past(n_tot)));

endmodule

bind spread_mod_top ssm_chk #(
   .INT_W  (INT_W),
   .FRAC_W (FRAC_W)
) u_chk (
   .clk_ref   (clk_ref),
   .rst_n     (rst_n),
   .ctrl_word (ctrl_word),
   .frac_mode (frac_mode),
   .nom_int   (nom_int),
   .nom_frac  (nom_frac),
   .out_int   (out_int),
   .out_frac  (out_frac),
   .out_valid (out_valid)
);

// File: tb/spread_mod_top_tb_top.sv
module spread_mod_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NV         = 9;
   localparam longint MASK36 = (longint'(1) << 36) - 1;

   // {ctrl[12:0], frac_mode, nom_int[11:0], nom_frac[23:0], cycles[15:0]}
   localparam logic [65:0] VEC [NV] = '{
      {13'h0830, 1'b1, 12'd50,   24'h000000, 16'd800},
      {13'h1F18, 1'b1, 12'd200,  24'h000000, 16'd300},
      {13'h0500, 1'b1, 12'd10,   24'hFFFFF0, 16'd300},
      {13'h0831, 1'b1, 12'd50,   24'h000000, 16'd100},
      {13'h0832, 1'b1, 12'd50,   24'h000000, 16'd100},
      {13'h0830, 1'b0, 12'd50,   24'h000000, 16'd100},
      {13'h0020, 1'b1, 12'd77,   24'h123456, 16'd300},
      {13'h14F8, 1'b1, 12'd4095, 24'h800000, 16'd2000},
      {13'h1F10, 1'b1, 12'd4095, 24'hFFFFFF, 16'd300}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] ctrl_w = '0;
   logic        fm = 1'b0;
   logic [11:0] nom_i = '0;
   logic [23:0] nom_f = '0;
   logic [11:0] out_int;
   logic [23:0] out_frac;
   logic        out_valid;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   longint m_out = 0;
   bit     m_valid = 1'b0;
   int     m_cnt = 0;
   int     m_idx = 0;

   bit     md_run;
   int     md_eff, md_ncnt, md_nidx;
   bit     md_stp;
   longint md_tot, md_ofs;

   always #(CLK_PERIOD/2) clk = ~clk;

   spread_mod_top dut_i (
      .clk_ref   (clk),
      .rst_n     (rst_n),
      .ctrl_word (ctrl_w),
      .frac_mode (fm),
      .nom_int   (nom_i),
      .nom_frac  (nom_f),
      .out_int   (out_int),
      .out_frac  (out_frac),
      .out_valid (out_valid)
   );

   function automatic longint exp_peak(longint tot, int amp);
      return (tot * amp + 500) / 1000;
   endfunction

   function automatic longint exp_wave(int idx, longint pk, bit down);
      int t;
      t = (idx < 64) ? idx : 128 - idx;
      if (down) return -((pk * t) >>> 6);
      return (pk * (2 * t - 64)) >>> 6;
   endfunction

   // cycle model built from R1..R11
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= 0; m_idx <= 0; m_out <= 0; m_valid <= 1'b0;
      end else begin
         md_run = fm && !ctrl_w[0] && !ctrl_w[1] && !ctrl_w[2];
         md_eff = (ctrl_w[7:4] == 4'd0) ? 1 : int'(ctrl_w[7:4]);
         if (!md_run) begin
            md_ncnt = 0; md_nidx = 0; md_stp = 1'b0;
         end else if (m_cnt >= md_eff - 1) begin
            md_ncnt = 0; md_nidx = (m_idx + 1) % 128; md_stp = 1'b1;
         end else begin
            md_ncnt = m_cnt + 1; md_nidx = m_idx; md_stp = 1'b0;
         end
         md_tot = longint'({nom_i, nom_f});
         md_ofs = md_run ? exp_wave(md_nidx, exp_peak(md_tot, int'(ctrl_w[12:8])), ctrl_w[3]) : 0;
         m_cnt   <= md_ncnt;
         m_idx   <= md_nidx;
         m_valid <= md_stp;
         m_out   <= (md_tot + md_ofs) & MASK36;
      end
   end

   task automatic check_val(string tag, longint got, longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic step_chk(string tag);
      @(posedge clk);
      @(negedge clk);
      check_val(tag, longint'({out_int, out_frac}), m_out);
      check_val(tag, longint'(out_valid), longint'(m_valid));
   endtask

   function automatic string vec_tag(int k);
      case (k)
         0: return "R7 center";
         1: return "R8 down";
         2: return "R5 R9 rate0 carry";
         3, 4, 5: return "R2 pass";
         6: return "R6 zero amp";
         7: return "R8 R9 slow down";
         default: return "R9 wrap";
      endcase
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int vcnt;
      int first_v;
      // R1 reset state
      @(negedge clk);
      check_val("R1 out in reset", longint'({out_int, out_frac}), 0);
      check_val("R1 valid in reset", longint'(out_valid), 0);
      ctrl_w = 13'h0834; fm = 1'b1; nom_i = 12'd50;
      @(negedge clk);
      check_val("R1 out held", longint'({out_int, out_frac}), 0);
      rst_n = 1'b1;

      // vector walk: modulator reset pulse, then run
      for (int k = 0; k < NV; k++) begin
         ctrl_w = VEC[k][65:53] | 13'h0004;
         fm     = VEC[k][52];
         nom_i  = VEC[k][51:40];
         nom_f  = VEC[k][39:16];
         for (int j = 0; j < 3; j++) step_chk("R3 hold");
         ctrl_w = VEC[k][65:53];
         for (int j = 0; j < int'(VEC[k][15:0]); j++) step_chk(vec_tag(k));
      end

      // R6 R8 fixed value: T=100<<24, SPREAD 31, down, index 64
      ctrl_w = 13'h1F1C; nom_i = 12'd100; nom_f = '0; fm = 1'b1;
      step_chk("R3 hold");
      step_chk("R3 hold");
      ctrl_w = 13'h1F18;
      for (int j = 0; j < 64; j++) step_chk("R11 down sweep");
      check_val("R6 peak at apex", longint'({out_int, out_frac}), 64'd1625712230);
      check_val("R11 valid at apex", longint'(out_valid), 1);
      for (int j = 0; j < 64; j++) step_chk("R11 down sweep");
      check_val("R4 wrap to index 0", longint'({out_int, out_frac}), 64'd1677721600);

      // R4 pulse count over one period at DIVVAL 5
      ctrl_w = 13'h0854; nom_i = 12'd300; nom_f = '0;
      step_chk("R3 hold");
      ctrl_w = 13'h0850;
      vcnt = 0;
      for (int j = 0; j < 640; j++) begin
         step_chk("R4 rate5");
         if (out_valid) vcnt++;
      end
      check_val("R4 pulses per period", vcnt, 128);

      // R10 live changes on advance edges (DIVVAL 1), no reset
      ctrl_w = 13'h0810;
      for (int j = 0; j < 100; j++) step_chk("R10 before change");
      ctrl_w = 13'h1418;
      for (int j = 0; j < 100; j++) step_chk("R10 amp dir change");
      ctrl_w = 13'h0C40;
      for (int j = 0; j < 200; j++) step_chk("R10 rate change");

      // R3 mid-run modulator reset, then restart from index 0 at DIVVAL 3
      ctrl_w = 13'h0C34;
      for (int j = 0; j < 5; j++) step_chk("R3 mid-run hold");
      check_val("R3 nominal while held", longint'({out_int, out_frac}), longint'({nom_i, nom_f}));
      ctrl_w = 13'h0C30;
      first_v = 0;
      for (int j = 1; j <= 20; j++) begin
         step_chk("R3 restart");
         if (out_valid && first_v == 0) first_v = j;
      end
      check_val("R3 first advance after release", first_v, 3);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule